// File: doc/BRIEF.md
# Access-Bit Translation Lookaside Buffer

This block is a small, fully associative cache of page translations that sits in front of a paged memory unit. Each lookup presents a virtual address and a privilege flag. One cycle later the block answers with a hit and the matching physical address, or with a miss. A miss means either that no entry holds the page or that the resident entry does not grant the requested privilege. A page-table walker outside the block loads new translations through a fill port. A flush input empties the whole buffer in one cycle.

Each entry carries a reference (access) bit. The bit is set when the entry is filled and whenever it produces a hit. A counter of lookups clears every reference bit once per refresh period. When a fill arrives and every slot is occupied, the block drops all entries that have not been referenced since the last clear. The new translation then takes the lowest freed slot. If every entry was referenced, a round-robin pointer chooses the slot to overwrite instead.

Both the lookup port and the fill port carry a valid strobe and have no ready signal. The block accepts one lookup and one fill in every cycle with no back-pressure. The lookup response is not held: it is valid for exactly one cycle, and the consumer must take it in that cycle. Flush is a plain control pin.

Top module: `tlb_access_evict`

## Requirements
- R1: After reset no entry is valid: `rsp_valid` and `rsp_hit` are 0, and the first lookup misses.
- R2: `rsp_valid` is 1 in the cycle after a cycle with `req_valid` high and 0 otherwise. Lookup results appear exactly one clock after the request.
- R3: A lookup hits when a valid entry's page number equals `req_vaddr[38:12]` and the permission test passes. `rsp_paddr` is then the entry's frame number concatenated with `req_vaddr[11:0]`. On a miss, `rsp_paddr` is 0.
- R4: The permission mask is 8'h08 when `req_sup`=1 and 8'h01 when `req_sup`=0. A tag match whose flags ANDed with the mask give zero is reported as a miss.
- R5: A fill writes the lowest-numbered free slot and sets that entry's reference bit. A lookup in the same cycle as the fill sees the table as it was before the fill, and the next lookup sees the new entry.
- R6: A fill whose page number is already resident overwrites that entry in place, so a later lookup returns the new frame and no duplicate is created.
- R7: A fill into a full buffer first invalidates every entry whose reference bit is clear, then writes the lowest freed slot. Entries referenced since the last clear survive.
- R8: If a fill finds the buffer full and every reference bit set, it overwrites the slot at a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, each time it is used.
- R9: Every REFRESH_RATE-th lookup (16 by default) clears all reference bits. If that lookup hits, its own entry's bit is set again after the clear.
- R10: `flush` invalidates every entry at the next edge. A fill in the same cycle as a flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 39 | Virtual address to translate |
| req_sup | input | 1 | 1 = supervisor access, 0 = user access |
| fill_valid | input | 1 | Fill request strobe |
| fill_vpn | input | 27 | Virtual page number to install |
| fill_pfn | input | 44 | Physical frame number to install |
| fill_flags | input | 8 | Permission flags of the new entry |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Lookup response valid, one cycle after the request |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_paddr | output | 56 | Physical address on a hit, 0 otherwise |

## Verification
All results are due one clock edge after their stimulus. A lookup's response is registered at the edge that captures the request. Fills, flushes and reference-bit clears change the table at that same edge, so they become visible to the lookup issued in the following cycle. The bench applies every operation at a falling edge and samples the response at the next falling edge, half a period after the capturing edge. It tracks the lookup count so that it knows which lookup triggers the periodic clear. It compares each response against a behavioural table model. The eviction and round-robin scenarios also carry fixed hit or miss expectations worked out by hand.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam logic [7:0] SUP_MASK = 8'h08;
  localparam logic [7:0] USR_MASK = 8'h01;

  function automatic logic [7:0] perm_mask(input logic sup);
    return sup ? SUP_MASK : USR_MASK;
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 8,
  parameter int VPN_W  = 27,
  parameter int PFN_W  = 44,
  parameter int FLAG_W = 8
) (
  input  logic [N-1:0]      vld,
  input  logic [VPN_W-1:0]  vpn_tab [N],
  input  logic [PFN_W-1:0]  pfn_tab [N],
  input  logic [FLAG_W-1:0] flg_tab [N],
  input  logic [VPN_W-1:0]  key,
  input  logic [FLAG_W-1:0] mask,
  output logic [N-1:0]      hit_vec,
  output logic              hit,
  output logic [PFN_W-1:0]  hit_pfn
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && (vpn_tab[g] == key) && ((flg_tab[g] & mask) != '0);
  end

  assign hit = |hit_vec;

  // at most one entry matches, so an OR of gated frames is a mux
  always_comb begin
    hit_pfn = '0;
    for (int i = 0; i < N; i++)
      hit_pfn = hit_pfn | ({PFN_W{hit_vec[i]}} & pfn_tab[i]);
  end
endmodule

// File: rtl/tlb_refresh.sv
module tlb_refresh #(
  parameter int RATE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic clr
);
  localparam int CNT_W = (RATE > 1) ? $clog2(RATE) : 1;
  logic [CNT_W-1:0] cnt_q;

  assign clr = tick && (cnt_q == CNT_W'(RATE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tlb_slot_pick.sv
module tlb_slot_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     dup_vec,
  input  logic [N-1:0]     free_vec,
  input  logic [IDX_W-1:0] rr_ptr,
  output logic [IDX_W-1:0] slot,
  output logic             use_rr
);
  // priority: resident page, then lowest free slot, then round robin
  always_comb begin
    slot   = rr_ptr;
    use_rr = 1'b1;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        slot   = IDX_W'(i);
        use_rr = 1'b0;
      end
    end
    if (|dup_vec) begin
      use_rr = 1'b0;
      for (int i = N - 1; i >= 0; i--)
        if (dup_vec[i]) slot = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_access_evict.sv
module tlb_access_evict #(
  parameter int ENTRIES      = 8,
  parameter int VPN_W        = 27,
  parameter int PFN_W        = 44,
  parameter int FLAG_W       = 8,
  parameter int OFF_W        = 12,
  parameter int REFRESH_RATE = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [VPN_W+OFF_W-1:0]   req_vaddr,
  input  logic                     req_sup,
  input  logic                     fill_valid,
  input  logic [VPN_W-1:0]         fill_vpn,
  input  logic [PFN_W-1:0]         fill_pfn,
  input  logic [FLAG_W-1:0]        fill_flags,
  input  logic                     flush,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic [PFN_W+OFF_W-1:0]   rsp_paddr
);
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q, acc_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [FLAG_W-1:0]  flg_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  logic [ENTRIES-1:0] hit_vec, dup_vec, evict_vec, free_vec, acc_mid;
  logic [ENTRIES-1:0] vld_n, acc_n;
  logic               lk_hit, refresh_clr, use_rr, fill_go, full, dup_any;
  logic [PFN_W-1:0]   lk_pfn;
  logic [IDX_W-1:0]   slot;
  logic [FLAG_W-1:0]  mask;

  assign mask = FLAG_W'(tlb_pkg::perm_mask(req_sup));

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .FLAG_W(FLAG_W)) u_match (
    .vld(vld_q), .vpn_tab(vpn_q), .pfn_tab(pfn_q), .flg_tab(flg_q),
    .key(req_vaddr[VA_W-1:OFF_W]), .mask(mask),
    .hit_vec(hit_vec), .hit(lk_hit), .hit_pfn(lk_pfn)
  );

  tlb_refresh #(.RATE(REFRESH_RATE)) u_refresh (
    .clk(clk), .rst_n(rst_n), .tick(req_valid), .clr(refresh_clr)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_dup
    assign dup_vec[g] = vld_q[g] && (vpn_q[g] == fill_vpn);
  end

  assign dup_any = |dup_vec;
  assign full    = &vld_q;
  assign fill_go = fill_valid && !flush;

  // reference bits after this cycle's clear and lookup, seen by the fill
  assign acc_mid   = (refresh_clr ? '0 : acc_q) | (req_valid ? hit_vec : '0);
  assign evict_vec = (fill_go && full && !dup_any) ? (vld_q & ~acc_mid) : '0;
  assign free_vec  = ~vld_q | evict_vec;

  tlb_slot_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .dup_vec(dup_vec), .free_vec(free_vec), .rr_ptr(rr_q),
    .slot(slot), .use_rr(use_rr)
  );

  always_comb begin
    vld_n = vld_q & ~evict_vec;
    acc_n = acc_mid & ~evict_vec;
    if (fill_go) begin
      vld_n[slot] = 1'b1;
      acc_n[slot] = 1'b1;
    end
    if (flush) begin
      vld_n = '0;
      acc_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      acc_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_n;
      acc_q <= acc_n;
      if (fill_go && use_rr)
        rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      vpn_q[slot] <= fill_vpn;
      pfn_q[slot] <= fill_pfn;
      flg_q[slot] <= fill_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && lk_hit;
      rsp_paddr <= (req_valid && lk_hit) ? {lk_pfn, req_vaddr[OFF_W-1:0]} : PA_W'(0);
    end
  end
endmodule

// File: rtl/tlb_access_evict_chk.sv
module tlb_access_evict_chk #(
  parameter int N    = 8,
  parameter int PA_W = 56
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            fill_valid,
  input logic            flush,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [N-1:0]    hit_vec,
  input logic [N-1:0]    vld_q,
  input logic [N-1:0]    acc_q,
  input logic            refresh_clr
);
  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0));
  // R1
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_hit);
  // R6
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));
  // R9
  refresh_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_clr && !flush) |=> ($countones(acc_q) <= 2));
  // R5
  fill_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush) |=> ((acc_q & vld_q) != '0));
endmodule

bind tlb_access_evict tlb_access_evict_chk #(.N(ENTRIES), .PA_W(PFN_W + OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .fill_valid(fill_valid),
  .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
  .hit_vec(hit_vec), .vld_q(vld_q), .acc_q(acc_q), .refresh_clr(refresh_clr)
);

// File: tb/test_tlb_access_evict.sv
`timescale 1ns/1ps
module test_tlb_access_evict;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [38:0] req_vaddr = '0;
  logic        req_sup = 1'b0;
  logic        fill_valid = 1'b0;
  logic [26:0] fill_vpn = '0;
  logic [43:0] fill_pfn = '0;
  logic [7:0]  fill_flags = '0;
  logic        flush = 1'b0;
  logic        rsp_valid, rsp_hit;
  logic [55:0] rsp_paddr;

  int total = 0;
  int bad = 0;
  bit summary_done = 0;

  always #2 clk = ~clk;

  tlb_access_evict i_tlb_access_evict (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_sup(req_sup), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_flags(fill_flags), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr)
  );

  // behavioural table model
  bit          m_vld [8];
  bit          m_acc [8];
  logic [26:0] m_vpn [8];
  logic [43:0] m_pfn [8];
  logic [7:0]  m_flg [8];
  int          m_rr = 0;
  int          m_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // one clock of stimulus; called at a falling edge, returns at the next one
  task automatic cycle_op(input bit lk, input logic [38:0] va, input bit sup,
                          input bit fl, input logic [26:0] fvpn, input logic [43:0] fpfn,
                          input logic [7:0] fflg, input bit fsh, input string req);
    bit          e_hit = 0;
    logic [55:0] e_pa = '0;
    int          e_idx = -1;
    int          slot = -1;
    bit          all_v = 1;
    logic [7:0]  msk = sup ? 8'h08 : 8'h01;
    if (lk)
      for (int i = 0; i < 8; i++)
        if (m_vld[i] && m_vpn[i] == va[38:12] && (m_flg[i] & msk) != 0) begin
          e_hit = 1; e_pa = {m_pfn[i], va[11:0]}; e_idx = i;
        end
    req_valid = lk; req_vaddr = va; req_sup = sup;
    fill_valid = fl; fill_vpn = fvpn; fill_pfn = fpfn; fill_flags = fflg; flush = fsh;
    @(posedge clk);
    if (lk) begin
      if (m_cnt == 15) begin
        m_cnt = 0;
        for (int i = 0; i < 8; i++) m_acc[i] = 0;
      end else m_cnt++;
      if (e_hit) m_acc[e_idx] = 1;
    end
    if (fsh) begin
      for (int i = 0; i < 8; i++) begin m_vld[i] = 0; m_acc[i] = 0; end
    end else if (fl) begin
      for (int i = 0; i < 8; i++) if (m_vld[i] && m_vpn[i] == fvpn) slot = i;
      if (slot < 0) begin
        for (int i = 0; i < 8; i++) if (!m_vld[i]) all_v = 0;
        if (all_v) for (int i = 0; i < 8; i++) if (!m_acc[i]) m_vld[i] = 0;
        for (int i = 7; i >= 0; i--) if (!m_vld[i]) slot = i;
        if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % 8; end
      end
      m_vld[slot] = 1; m_acc[slot] = 1;
      m_vpn[slot] = fvpn; m_pfn[slot] = fpfn; m_flg[slot] = fflg;
    end
    @(negedge clk);
    req_valid = 0; fill_valid = 0; flush = 0;
    chk(rsp_valid == lk, "R2", "rsp_valid", 64'(rsp_valid), 64'(lk));
    if (lk) begin
      chk(rsp_hit == e_hit, req, "rsp_hit", 64'(rsp_hit), 64'(e_hit));
      chk(rsp_paddr == e_pa, req, "rsp_paddr", 64'(rsp_paddr), 64'(e_pa));
    end
  endtask

  task automatic look(input logic [38:0] va, input bit sup, input string req);
    cycle_op(1, va, sup, 0, '0, '0, '0, 0, req);
  endtask

  task automatic look_exp(input logic [26:0] vpn, input bit exp, input string req);
    look({vpn, 12'h000}, 1'b0, req);
    chk(rsp_hit == exp, req, "fixed expectation hit", 64'(rsp_hit), 64'(exp));
  endtask

  task automatic fill(input logic [26:0] vpn, input logic [43:0] pfn, input logic [7:0] flg);
    cycle_op(0, '0, 0, 1, vpn, pfn, flg, 0, "R5");
  endtask

  task automatic idle();
    cycle_op(0, '0, 0, 0, '0, '0, '0, 0, "R2");
  endtask

  task automatic t_reset();
    chk(rsp_valid == 0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk(rsp_hit == 0, "R1", "rsp_hit after reset", 64'(rsp_hit), 64'd0);
    look_exp(27'h0, 0, "R1");
  endtask

  task automatic t_fill_hit();
    // R5: the lookup in the fill cycle sees the old table
    cycle_op(1, {27'h12345, 12'h7A3}, 0, 1, 27'h12345, 44'hABCDE, 8'h09, 0, "R5");
    chk(rsp_hit == 0, "R5", "same-cycle lookup", 64'(rsp_hit), 64'd0);
    look({27'h12345, 12'h7A3}, 0, "R3");
    chk(rsp_paddr == {44'hABCDE, 12'h7A3}, "R3", "paddr", 64'(rsp_paddr),
        64'({44'hABCDE, 12'h7A3}));
    idle();
  endtask

  task automatic t_perm();
    fill(27'h20, 44'h111, 8'h08);
    look({27'h20, 12'h010}, 0, "R4");
    chk(rsp_hit == 0, "R4", "user on supervisor page", 64'(rsp_hit), 64'd0);
    look({27'h20, 12'h010}, 1, "R4");
    chk(rsp_hit == 1, "R4", "supervisor on supervisor page", 64'(rsp_hit), 64'd1);
    fill(27'h21, 44'h222, 8'h02);
    look({27'h21, 12'h0}, 0, "R4");
    look({27'h21, 12'h0}, 1, "R4");
    chk(rsp_hit == 0, "R4", "no permission bit", 64'(rsp_hit), 64'd0);
  endtask

  task automatic t_dup();
    fill(27'h12345, 44'h555, 8'h01);
    look({27'h12345, 12'h001}, 0, "R6");
    chk(rsp_paddr == {44'h555, 12'h001}, "R6", "overwritten frame", 64'(rsp_paddr),
        64'({44'h555, 12'h001}));
  endtask

  task automatic t_flush();
    cycle_op(0, '0, 0, 0, '0, '0, '0, 1, "R10");
    look_exp(27'h12345, 0, "R10");
    cycle_op(0, '0, 0, 1, 27'h77, 44'h77, 8'h09, 1, "R10");
    look_exp(27'h77, 0, "R10");
  endtask

  task automatic fill_eight();
    cycle_op(0, '0, 0, 0, '0, '0, '0, 1, "R10");
    for (int i = 0; i < 8; i++) fill(27'h100 + 27'(i), 44'h1000 + 44'(i), 8'h09);
  endtask

  task automatic t_evict();
    bit last;
    fill_eight();
    do begin
      last = (m_cnt == 15);
      look({27'h7FFF, 12'h0}, 0, "R9");
    end while (!last);
    look_exp(27'h102, 1, "R7");
    look_exp(27'h105, 1, "R7");
    fill(27'h200, 44'h2000, 8'h09);
    look_exp(27'h100, 0, "R7");
    look_exp(27'h101, 0, "R7");
    look_exp(27'h102, 1, "R7");
    look_exp(27'h105, 1, "R7");
    look_exp(27'h200, 1, "R7");
  endtask

  task automatic t_rr();
    fill_eight();
    fill(27'h300, 44'h3000, 8'h09);
    look_exp(27'h100, 0, "R8");
    look_exp(27'h300, 1, "R8");
    look_exp(27'h101, 1, "R8");
    fill(27'h301, 44'h3001, 8'h09);
    look_exp(27'h101, 0, "R8");
    look_exp(27'h301, 1, "R8");
  endtask

  task automatic t_refresh();
    while (m_cnt != 15) look({27'h7FFF, 12'h0}, 0, "R9");
    look_exp(27'h102, 1, "R9");
    fill(27'h400, 44'h4000, 8'h09);
    look_exp(27'h102, 1, "R9");
    look_exp(27'h103, 0, "R9");
    look_exp(27'h301, 0, "R9");
    look_exp(27'h400, 1, "R9");
  endtask

  initial begin
    #(4 * 100000);
    chk(0, "watchdog", "run timed out", 64'd1, 64'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_hit();
    t_perm();
    t_dup();
    t_flush();
    t_evict();
    t_rr();
    t_refresh();
    idle();
    finish_run();
  end
endmodule